// File: doc/BRIEF.md
# Serial Management Slave with PHY Register File

This block is the target side of a two-wire management bus: a clock line (MDC) driven by a station manager and a bidirectional data line. It decodes each frame one bit per MDC rising edge. A frame is a long run of ones, a low bit, a high start bit, a 2-bit opcode, the 5-bit PHY address, the 5-bit register number, two turnaround bits and a 16-bit data word, each field MSB first. One register file sits behind the decoder. Its 5-bit address comes from a pin, so a board strap selects it.

Most of the 32 registers simply hold what was last written. Three registers are built from live state when they are read: the status word, the link-partner ability word and a diagnostics word. Their values depend on the link input and on the local advertisement register, so a host that advertises any mode sees the partner agree with it. On a read, the slave drives the data line (`mdio_o` with `mdio_oe`) for the sixteen data bits only, and changes the bit on MDC falling edges. On a write, the received word lands in the register file after the last data bit. MDC and the data input are sampled by the system clock `clk`, which must run at least four times faster than MDC.

Top module: `mdio_phy_slave`

## Requirements
- R1: After reset, `mdio_oe` is low and `mdio_o` is low. Register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 (advertisement) reads 0x01E1, and the stored registers not listed read 0x0000.
- R2: A low data bit on a rising MDC edge starts a frame only after at least PRE_LEN (default 32) consecutive high bits. An earlier low bit restarts the count, and the frame that follows gets no response.
- R3: The bit after the frame-opening low bit must be high. If it is low, the frame is abandoned and the slave hunts for a new preamble.
- R4: For a read (opcode binary 10) addressed to this slave, `mdio_oe` is high for exactly the 16 data bits. The word is driven MSB first, and `mdio_o` changes only after MDC falling edges. The line is released at the 16th data rising edge.
- R5: For a write addressed to this slave, the 16 data bits are committed to the register named in the frame once the last bit is sampled. A later read of a stored register returns that word.
- R6: Every opcode other than binary 10 (00, 01, 11) is handled as a write, and `mdio_oe` stays low for it.
- R7: A read to another PHY address returns 0xFFFF on the line when DRIVE_UNMATCHED is 1, and leaves the line undriven when it is 0. A write to another address changes no register.
- R8: Register 1 reads 0x782C (bits 14, 13, 12, 11, 5, 3, 2) while `link_up` is high, and 0x0000 while it is low.
- R9: Register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R10: Register 18 reads 0x0000 while `link_up` is low. Otherwise bit 10 is register 4 bit 7 OR bit 8, bit 11 is register 4 bit 8 OR bit 6, and all other bits are 0.
- R11: The slave answers the address on `phy_addr`, and a change of that pin moves it to the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples MDC and data |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Data line as seen at the pad |
| link_up | input | 1 | Current link state, feeds registers 1 and 18 |
| phy_addr | input | 5 | Address this slave answers to |
| mdio_o | output | 1 | Data bit driven during a read |
| mdio_oe | output | 1 | Drive enable for the data pad |

## Verification
The bench builds the block with PRE_LEN at 32 and DRIVE_UNMATCHED at 1. This exposes the full-length preamble rule and the all-ones reply from an absent address. The advertisement register is rewritten with 100-only, full-duplex-only and mixed patterns, so every derived bit of registers 5 and 18 is seen both set and clear, under link up and link down. The undriven variant of R7 is not reached with these values. A move of `phy_addr` shows the same frames switching between the answered and the absent paths.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic [2:0] {
    FR_HUNT, FR_START, FR_OPC, FR_PHYA, FR_REGA, FR_TURN, FR_DATA
  } fr_state_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 5;
  localparam logic [1:0]  OPC_RD = 2'b10;

  function automatic logic [4:0] phase_bits(input fr_state_e st);
    case (st)
      FR_OPC:  phase_bits = 5'd2;
      FR_PHYA: phase_bits = 5'd5;
      FR_REGA: phase_bits = 5'd5;
      FR_TURN: phase_bits = 5'd2;
      FR_DATA: phase_bits = 5'd16;
      default: phase_bits = 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_slv_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_rise,
  input  logic              mdio_in,
  output logic              rd_req,
  output logic              wr_req,
  output logic              in_data,
  output logic              is_read,
  output logic [ADDR_W-1:0] phy_sel,
  output logic [ADDR_W-1:0] reg_sel,
  output logic [WORD_W-1:0] wdata
);
  localparam int unsigned PW = $clog2(PRE_LEN + 1);

  fr_state_e         state_q, state_d;
  logic [4:0]        cnt_q, cnt_d;
  logic [PW-1:0]     pre_q, pre_d;
  logic [WORD_W-2:0] sh_q;
  logic [1:0]        opc_q;
  logic              last;

  assign last    = (cnt_q == phase_bits(state_q) - 5'd1);
  assign is_read = (opc_q == OPC_RD);
  assign in_data = (state_q == FR_DATA);
  assign wdata   = {sh_q, mdio_in};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    rd_req  = 1'b0;
    wr_req  = 1'b0;
    if (mdc_rise) begin
      case (state_q)
        FR_HUNT: begin
          if (!mdio_in) begin
            if (pre_q >= PW'(PRE_LEN)) state_d = FR_START;
            pre_d = '0;
          end else if (pre_q < PW'(PRE_LEN)) begin
            pre_d = pre_q + 1'b1;
          end
        end
        FR_START: begin
          cnt_d   = '0;
          state_d = mdio_in ? FR_OPC : FR_HUNT;
        end
        default: begin
          if (last) begin
            cnt_d = '0;
            case (state_q)
              FR_OPC:  state_d = FR_PHYA;
              FR_PHYA: state_d = FR_REGA;
              FR_REGA: state_d = FR_TURN;
              FR_TURN: begin
                state_d = FR_DATA;
                rd_req  = is_read;
              end
              default: begin
                state_d = FR_HUNT;
                wr_req  = !is_read;
              end
            endcase
          end else begin
            cnt_d = cnt_q + 5'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_HUNT;
      cnt_q   <= '0;
      pre_q   <= '0;
      sh_q    <= '0;
      opc_q   <= '0;
      phy_sel <= '0;
      reg_sel <= '0;
    end else if (mdc_rise) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      sh_q    <= {sh_q[WORD_W-3:0], mdio_in};
      if (state_q == FR_OPC  && last) opc_q   <= {sh_q[0], mdio_in};
      if (state_q == FR_PHYA && last) phy_sel <= {sh_q[3:0], mdio_in};
      if (state_q == FR_REGA && last) reg_sel <= {sh_q[3:0], mdio_in};
    end
  end

  AST_START_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_START && $past(state_q) == FR_HUNT) |-> ($past(pre_q) >= PW'(PRE_LEN))); // R2
  AST_ABORT_ON_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_START && mdc_rise && !mdio_in) |=> (state_q == FR_HUNT)); // R3
  AST_WRITE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (opc_q != OPC_RD)); // R6
  AST_WRITE_AT_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (state_q == FR_DATA && cnt_q == 5'd15)); // R5
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_slv_pkg::*;
#(
  parameter int unsigned NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] RN_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] RN_ADV  = 5'd4;
  localparam logic [ADDR_W-1:0] RN_LPA  = 5'd5;
  localparam logic [ADDR_W-1:0] RN_DIAG = 5'd18;
  localparam logic [WORD_W-1:0] STAT_UP = 16'h782C;

  logic [WORD_W-1:0] mem [NREG];
  logic [WORD_W-1:0] adv;

  function automatic logic [WORD_W-1:0] init_val(input int unsigned idx);
    case (idx)
      0:       init_val = 16'h3100;
      2:       init_val = 16'h0300;
      3:       init_val = 16'hE400;
      4:       init_val = 16'h01E1;
      default: init_val = 16'h0000;
    endcase
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[g] <= init_val(g);
      else if (we && waddr == ADDR_W'(g))   mem[g] <= wdata;
    end
  end

  assign adv = mem[RN_ADV];

  always_comb begin
    case (raddr)
      RN_STAT: rdata = link_up ? STAT_UP : '0;
      RN_LPA:  rdata = 16'h4000 | (adv & 16'h01E0) | 16'h0001;
      RN_DIAG: rdata = link_up ? {4'b0, adv[8] | adv[6], adv[8] | adv[7], 10'b0} : '0;
      default: rdata = mem[raddr];
    endcase
  end

  AST_ADV_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == RN_ADV) |=> (adv == $past(wdata))); // R5
  AST_ADV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && waddr == RN_ADV) |=> $stable(adv)); // R7
endmodule

// File: rtl/mdio_tx_drv.sv
module mdio_tx_drv
  import mdio_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_fall,
  input  logic              load,
  input  logic              enable,
  input  logic [WORD_W-1:0] word,
  input  logic              done,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [WORD_W-1:0] sh_q;
  logic              armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      armed_q <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      if (load) begin
        sh_q    <= word;
        armed_q <= enable;
      end else if (done) begin
        armed_q <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (mdc_fall && armed_q) begin
        mdio_o  <= sh_q[WORD_W-1];
        sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
        mdio_oe <= 1'b1;
      end
    end
  end

  AST_BIT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_fall |=> $stable(mdio_o)); // R4
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mdio_oe); // R4
endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave
  import mdio_slv_pkg::*;
#(
  parameter int unsigned PRE_LEN         = 32,
  parameter int unsigned NREG            = 32,
  parameter bit          DRIVE_UNMATCHED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       mdio_i,
  input  logic       link_up,
  input  logic [4:0] phy_addr,
  output logic       mdio_o,
  output logic       mdio_oe
);
  logic              mdc_q, mdc_rise, mdc_fall;
  logic              rd_req, wr_req, in_data, is_read, hit;
  logic [ADDR_W-1:0] phy_sel, reg_sel;
  logic [WORD_W-1:0] wdata, rdata, tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc;
  end
  assign mdc_rise = mdc & ~mdc_q;
  assign mdc_fall = ~mdc & mdc_q;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_in(mdio_i),
    .rd_req(rd_req), .wr_req(wr_req), .in_data(in_data), .is_read(is_read),
    .phy_sel(phy_sel), .reg_sel(reg_sel), .wdata(wdata)
  );

  assign hit     = (phy_sel == phy_addr);
  assign tx_word = hit ? rdata : '1;

  mdio_phy_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .we(wr_req && hit), .waddr(reg_sel), .wdata(wdata),
    .raddr(reg_sel), .rdata(rdata)
  );

  mdio_tx_drv u_tx (
    .clk(clk), .rst_n(rst_n), .mdc_fall(mdc_fall),
    .load(rd_req), .enable(hit || DRIVE_UNMATCHED), .word(tx_word),
    .done(mdc_rise && in_data && wr_req == 1'b0 && is_read && u_rx.cnt_q == 5'd15),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (in_data && is_read)); // R4
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read |-> !mdio_oe); // R6
endmodule

// File: tb/sim_mdio_phy_slave.sv
module sim_mdio_phy_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdc = 1'b0;
  logic       mdio_i = 1'b1;
  logic       link_up = 1'b1;
  logic [4:0] phy_addr = 5'd1;
  logic       mdio_o, mdio_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic       smp_o;
  logic       smp_oe;

  always #5 clk = ~clk;

  mdio_phy_slave u0 (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
    .link_up(link_up), .phy_addr(phy_addr), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // link, register number, expected read word
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 5'd0,  16'h3100},  // R1
    {1'b1, 5'd2,  16'h0300},  // R1
    {1'b1, 5'd3,  16'hE400},  // R1
    {1'b1, 5'd4,  16'h01E1},  // R1
    {1'b1, 5'd7,  16'h0000},  // R1
    {1'b1, 5'd1,  16'h782C},  // R8
    {1'b0, 5'd1,  16'h0000},  // R8
    {1'b1, 5'd5,  16'h41E1},  // R9
    {1'b1, 5'd18, 16'h0C00},  // R10
    {1'b0, 5'd18, 16'h0000}   // R10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one_bit(input logic b);
    @(negedge clk);
    mdc = 1'b0;
    mdio_i = b;
    repeat (4) @(negedge clk);
    smp_o  = mdio_o;
    smp_oe = mdio_oe;
    mdc = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int pre, input logic sb,
                       output logic [15:0] rd, output int oe_n);
    oe_n = 0;
    rd   = '0;
    for (int i = 0; i < pre; i++) one_bit(1'b1);
    one_bit(1'b0);
    one_bit(sb);
    for (int i = 1; i >= 0; i--) begin one_bit(op[i]); oe_n += int'(smp_oe); end
    for (int i = 4; i >= 0; i--) begin one_bit(pa[i]); oe_n += int'(smp_oe); end
    for (int i = 4; i >= 0; i--) begin one_bit(ra[i]); oe_n += int'(smp_oe); end
    one_bit(1'b1); oe_n += int'(smp_oe);
    one_bit(op == 2'b10); oe_n += int'(smp_oe);
    for (int i = 15; i >= 0; i--) begin
      one_bit(wd[i]);
      oe_n += int'(smp_oe);
      rd[i] = smp_o;
    end
    one_bit(1'b1);
    oe_n += int'(smp_oe);
  endtask

  task automatic rd_reg(input logic [4:0] pa, input logic [4:0] ra,
                        output logic [15:0] rd, output int oe_n);
    frame(2'b10, pa, ra, 16'hFFFF, 32, 1'b1, rd, oe_n);
  endtask

  task automatic wr_reg(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, output int oe_n);
    logic [15:0] dummy;
    frame(op, pa, ra, wd, 32, 1'b1, dummy, oe_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int oe_n;
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", {15'b0, mdio_oe}, 16'h0000);
    chk("R1 data after reset", {15'b0, mdio_o}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      link_up = VEC[v][21];
      rd_reg(5'd1, VEC[v][20:16], rd, oe_n);
      chk("R1/R8/R9/R10 table read", rd, VEC[v][15:0]);
      chk("R4 oe bit count", 16'(oe_n), 16'd16);
    end
    link_up = 1'b1;

    // R5, R6: opcode 01 write, then 11 and 00 writes
    wr_reg(2'b01, 5'd1, 5'd9, 16'hA5C3, oe_n);
    chk("R6 no drive on write", 16'(oe_n), 16'd0);
    rd_reg(5'd1, 5'd9, rd, oe_n);
    chk("R5 write readback", rd, 16'hA5C3);
    wr_reg(2'b11, 5'd1, 5'd20, 16'h1234, oe_n);
    rd_reg(5'd1, 5'd20, rd, oe_n);
    chk("R6 opcode 11 writes", rd, 16'h1234);
    wr_reg(2'b00, 5'd1, 5'd20, 16'h8001, oe_n);
    rd_reg(5'd1, 5'd20, rd, oe_n);
    chk("R6 opcode 00 writes", rd, 16'h8001);

    // R9, R10 with other advertisement patterns
    wr_reg(2'b01, 5'd1, 5'd4, 16'h0140, oe_n);
    rd_reg(5'd1, 5'd5, rd, oe_n);
    chk("R9 partner from 0x0140", rd, 16'h4141);
    rd_reg(5'd1, 5'd18, rd, oe_n);
    chk("R10 diag from 0x0140", rd, 16'h0C00);
    wr_reg(2'b01, 5'd1, 5'd4, 16'h0080, oe_n);
    rd_reg(5'd1, 5'd18, rd, oe_n);
    chk("R10 diag 100 half", rd, 16'h0400);
    rd_reg(5'd1, 5'd5, rd, oe_n);
    chk("R9 partner from 0x0080", rd, 16'h4081);
    wr_reg(2'b01, 5'd1, 5'd4, 16'h0040, oe_n);
    rd_reg(5'd1, 5'd18, rd, oe_n);
    chk("R10 diag 10 full", rd, 16'h0800);
    wr_reg(2'b01, 5'd1, 5'd4, 16'h0020, oe_n);
    rd_reg(5'd1, 5'd18, rd, oe_n);
    chk("R10 diag 10 half", rd, 16'h0000);

    // R7: absent address
    rd_reg(5'd7, 5'd9, rd, oe_n);
    chk("R7 absent read value", rd, 16'hFFFF);
    chk("R7 absent read drive", 16'(oe_n), 16'd16);
    wr_reg(2'b01, 5'd7, 5'd9, 16'h0000, oe_n);
    rd_reg(5'd1, 5'd9, rd, oe_n);
    chk("R7 absent write ignored", rd, 16'hA5C3);

    // R2: short preamble gets no answer, then a proper frame works
    frame(2'b10, 5'd1, 5'd0, 16'hFFFF, 10, 1'b1, rd, oe_n);
    chk("R2 short preamble ignored", 16'(oe_n), 16'd0);
    frame(2'b01, 5'd1, 5'd9, 16'h0F0F, 10, 1'b1, rd, oe_n);
    rd_reg(5'd1, 5'd9, rd, oe_n);
    chk("R2 short preamble write ignored", rd, 16'hA5C3);

    // R3: low start bit abandons the frame
    frame(2'b10, 5'd1, 5'd0, 16'hFFFF, 32, 1'b0, rd, oe_n);
    chk("R3 bad start no drive", 16'(oe_n), 16'd0);
    frame(2'b01, 5'd1, 5'd9, 16'h0F0F, 32, 1'b0, rd, oe_n);
    rd_reg(5'd1, 5'd9, rd, oe_n);
    chk("R3 bad start write ignored", rd, 16'hA5C3);
    chk("R3 recovery read drive", 16'(oe_n), 16'd16);

    // R11: move the strap
    phy_addr = 5'd3;
    rd_reg(5'd3, 5'd0, rd, oe_n);
    chk("R11 new address answers", rd, 16'h3100);
    rd_reg(5'd1, 5'd0, rd, oe_n);
    chk("R11 old address absent", rd, 16'hFFFF);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule